// File: doc/BRIEF.md
# Interlocked Parallel Port Handshake Unit

This block moves bytes across an 8-bit parallel port with a two-wire, fully interlocked strobe/acknowledge handshake. A mode input picks the direction at run time. As a receiver, it watches an active-low data-valid strobe from the sender. It captures the port byte when that strobe falls, then withdraws its ready output. Ready comes back only after the sender releases the strobe and the core has taken the byte. As a transmitter, it puts a byte from the core on the port pins. One clock later it lowers its own data-valid strobe, and it waits for the far end's ready to fall and then rise again before it reports the transfer as done.

Both external handshake inputs are resynchronised by a two-stage flip-flop chain before the control logic sees them. The core side has a write strobe with write data, a read strobe with read data, and a single flag. The flag means "byte waiting" in receive mode and "transfer complete" in transmit mode, and it can serve as an interrupt request.

Top module: `strobe_port_hs`

## Requirements
- R1: While reset is held and just after it, `flag_o` is 0 and `dav_n_o` is 1. `rdy_o` is 1 when `mode_i`=0 (receive) and 0 when `mode_i`=1 (transmit). `port_oe_o` equals `mode_i`. `rdy_o` and a low `dav_n_o` are never seen together.
- R2: `dav_n_i` and `rdy_i` are each resynchronised through two flip-flops. A change applied between clock edges takes effect at the third rising edge after it, and not earlier.
- R3: In receive mode, a high-to-low transition of `dav_n_i` copies `port_d_i` into the holding register on `rdata_o`. At that same edge (the third after the fall) `rdy_o` drops to 0 and `flag_o` rises to 1.
- R4: In receive mode, `rdy_o` returns to 1 only once `dav_n_i` has been seen high and the byte has been read. It rises on the edge after both conditions hold. A read while the strobe is still low, or a release with no read, leaves `rdy_o` at 0.
- R5: In receive mode, while a byte is held, changes on `port_d_i` and further strobe pulses on `dav_n_i` do not alter `rdata_o`.
- R6: A one-cycle `rd_i` pulse clears `flag_o` at the next rising edge, in either mode.
- R7: In transmit mode, a `wr_i` pulse while idle drives `wdata_i` onto `port_d_o` and clears `flag_o` at the next edge. `dav_n_o` falls exactly one clock after that.
- R8: In transmit mode, `dav_n_o` stays low until `rdy_i` has gone low. It returns high at the third edge after `rdy_i` falls.
- R9: In transmit mode, `flag_o` rises at the third edge after `rdy_i` rises again, following the strobe release. While the unit is busy, `wr_i` is ignored: `port_d_o` and the handshake sequence are not changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = receive, 1 = transmit |
| port_d_i | input | 8 | Port data from the pins (receive) |
| port_d_o | output | 8 | Port data to the pins (transmit) |
| port_oe_o | output | 1 | Port pin output enable |
| dav_n_i | input | 1 | Data-valid strobe from sender, active low |
| dav_n_o | output | 1 | Data-valid strobe to receiver, active low |
| rdy_i | input | 1 | Ready from the far receiver |
| rdy_o | output | 1 | Ready to the far sender |
| wr_i | input | 1 | Core write strobe |
| wdata_i | input | 8 | Core write data |
| rd_i | input | 1 | Core read strobe |
| rdata_o | output | 8 | Received byte |
| flag_o | output | 1 | Byte waiting / transfer done, interrupt capable |

## Verification
Every one of the 256 byte values is received and every one is sent, so a bit stuck or swapped in either data path shows up. Receive transfers alternate between two orders: the core read before the strobe release, and the release before the read. This separates a ready that waits for both conditions from one that waits for only one. Port data is disturbed and the strobe is pulsed again while a byte is held, to expose overwrite. In transmit mode, a write is attempted during the strobe phase, and the edges of `dav_n_o` and `flag_o` are sampled at exact cycle counts. Together these pin down the one-clock setup delay and the synchroniser latency.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic {
    IN_IDLE,
    IN_HELD
  } in_state_e;

  typedef enum logic [1:0] {
    OUT_IDLE,
    OUT_SETUP,
    OUT_STROBE,
    OUT_RELEASE
  } out_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[LAST];
endmodule

// File: rtl/hs_in_ctrl.sv
module hs_in_ctrl
  import hs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          dav_s_i,
  input  logic [DW-1:0] port_d_i,
  input  logic          rd_i,
  output logic          rdy_o,
  output logic          flag_o,
  output logic [DW-1:0] hold_o
);
  in_state_e     state_q;
  logic          dav_d_q;
  logic          flag_q;
  logic [DW-1:0] hold_q;
  logic          dav_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dav_d_q <= 1'b1;
    else         dav_d_q <= dav_s_i;
  end

  assign dav_fall = dav_d_q & ~dav_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= IN_IDLE;
      flag_q  <= 1'b0;
      hold_q  <= '0;
    end else if (clr_i) begin
      state_q <= IN_IDLE;
      flag_q  <= 1'b0;
    end else begin
      unique case (state_q)
        IN_IDLE: begin
          if (dav_fall) begin
            hold_q  <= port_d_i;
            flag_q  <= 1'b1;
            state_q <= IN_HELD;
          end
        end
        IN_HELD: begin
          if (rd_i) flag_q <= 1'b0;
          // leave only once strobe released and byte consumed
          if (dav_s_i && !flag_q) state_q <= IN_IDLE;
        end
        default: state_q <= IN_IDLE;
      endcase
    end
  end

  assign rdy_o  = (state_q == IN_IDLE);
  assign flag_o = flag_q;
  assign hold_o = hold_q;

  p_rdy_waits_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rdy_o) && !$past(clr_i)) |-> ($past(dav_s_i) && !$past(flag_q)));

  p_no_overwrite_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> $stable(hold_q));

  p_read_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && rd_i) |=> !flag_q);
endmodule

// File: rtl/hs_out_ctrl.sv
module hs_out_ctrl
  import hs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          rdy_s_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] data_o,
  output logic          dav_n_o,
  output logic          flag_o
);
  out_state_e    state_q;
  logic [DW-1:0] data_q;
  logic          dav_n_q;
  logic          flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= OUT_IDLE;
      data_q  <= '0;
      dav_n_q <= 1'b1;
      flag_q  <= 1'b0;
    end else if (clr_i) begin
      state_q <= OUT_IDLE;
      dav_n_q <= 1'b1;
      flag_q  <= 1'b0;
    end else begin
      if (rd_i) flag_q <= 1'b0;
      unique case (state_q)
        OUT_IDLE: begin
          if (wr_i) begin
            data_q  <= wdata_i;
            flag_q  <= 1'b0;
            state_q <= OUT_SETUP;
          end
        end
        OUT_SETUP: begin
          dav_n_q <= 1'b0;
          state_q <= OUT_STROBE;
        end
        OUT_STROBE: begin
          if (!rdy_s_i) begin
            dav_n_q <= 1'b1;
            state_q <= OUT_RELEASE;
          end
        end
        OUT_RELEASE: begin
          if (rdy_s_i) begin
            flag_q  <= 1'b1;
            state_q <= OUT_IDLE;
          end
        end
        default: state_q <= OUT_IDLE;
      endcase
    end
  end

  assign data_o  = data_q;
  assign dav_n_o = dav_n_q;
  assign flag_o  = flag_q;

  p_dav_after_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dav_n_q) |-> $stable(data_q));

  p_dav_rise_after_rdy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dav_n_q) && !$past(clr_i)) |-> !$past(rdy_s_i));

  p_busy_write_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && state_q != OUT_IDLE && !clr_i) |=> $stable(data_q));

  p_done_after_rdy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> ($past(rdy_s_i) && dav_n_q));
endmodule

// File: rtl/strobe_port_hs.sv
module strobe_port_hs #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic [DW-1:0] port_d_i,
  output logic [DW-1:0] port_d_o,
  output logic          port_oe_o,
  input  logic          dav_n_i,
  output logic          dav_n_o,
  input  logic          rdy_i,
  output logic          rdy_o,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          flag_o
);
  logic dav_s, rdy_s;
  logic in_rdy, in_flag;
  logic out_dav_n, out_flag;

  hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dav (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (dav_n_i),
    .q_o   (dav_s)
  );

  hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rdy (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rdy_i),
    .q_o   (rdy_s)
  );

  hs_in_ctrl #(.DW(DW)) u_in (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (mode_i),
    .dav_s_i (dav_s),
    .port_d_i(port_d_i),
    .rd_i    (rd_i),
    .rdy_o   (in_rdy),
    .flag_o  (in_flag),
    .hold_o  (rdata_o)
  );

  hs_out_ctrl #(.DW(DW)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~mode_i),
    .rdy_s_i(rdy_s),
    .wr_i   (wr_i),
    .wdata_i(wdata_i),
    .rd_i   (rd_i),
    .data_o (port_d_o),
    .dav_n_o(out_dav_n),
    .flag_o (out_flag)
  );

  assign port_oe_o = mode_i;
  assign rdy_o     = ~mode_i & in_rdy;
  assign dav_n_o   = ~mode_i | out_dav_n;
  assign flag_o    = mode_i ? out_flag : in_flag;

  p_strobes_exclusive_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rdy_o && !dav_n_o));
endmodule

// File: tb/strobe_port_hs_bench.sv
`timescale 1ns/1ps
module strobe_port_hs_bench;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       mode_i;
  logic [7:0] port_d_i;
  logic [7:0] port_d_o;
  logic       port_oe_o;
  logic       dav_n_i;
  logic       dav_n_o;
  logic       rdy_i;
  logic       rdy_o;
  logic       wr_i;
  logic [7:0] wdata_i;
  logic       rd_i;
  logic [7:0] rdata_o;
  logic       flag_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  strobe_port_hs u_strobe_port_hs (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i),
    .port_d_i(port_d_i), .port_d_o(port_d_o), .port_oe_o(port_oe_o),
    .dav_n_i(dav_n_i), .dav_n_o(dav_n_o), .rdy_i(rdy_i), .rdy_o(rdy_o),
    .wr_i(wr_i), .wdata_i(wdata_i), .rd_i(rd_i), .rdata_o(rdata_o),
    .flag_o(flag_o)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd_pulse();
    rd_i = 1'b1;
    step(1);
    rd_i = 1'b0;
  endtask

  task automatic recv(input logic [7:0] d, input bit read_first);
    port_d_i = d;
    dav_n_i  = 1'b0;
    step(2);
    chk("R2 rdy before sync", rdy_o, 1);
    chk("R2 flag before sync", flag_o, 0);
    step(1);
    chk("R3 rdy low", rdy_o, 0);
    chk("R3 flag set", flag_o, 1);
    chk("R3 data latched", rdata_o, d);
    port_d_i = ~d;
    if (read_first) begin
      rd_pulse();
      chk("R6 flag cleared", flag_o, 0);
      step(2);
      chk("R4 read but strobe low", rdy_o, 0);
      dav_n_i = 1'b1;
      step(2);
      chk("R4 release in sync", rdy_o, 0);
      step(1);
      chk("R4 rdy back", rdy_o, 1);
      chk("R5 data kept", rdata_o, d);
    end else begin
      dav_n_i = 1'b1;
      step(3);
      chk("R4 released unread", rdy_o, 0);
      dav_n_i = 1'b0;
      step(4);
      chk("R5 second strobe ignored", rdata_o, d);
      chk("R5 flag still set", flag_o, 1);
      dav_n_i = 1'b1;
      step(3);
      rd_pulse();
      chk("R6 flag cleared", flag_o, 0);
      chk("R4 rdy one edge later", rdy_o, 0);
      step(1);
      chk("R4 rdy back", rdy_o, 1);
      chk("R5 data kept", rdata_o, d);
    end
  endtask

  task automatic send(input logic [7:0] d);
    wdata_i = d;
    wr_i    = 1'b1;
    step(1);
    wr_i = 1'b0;
    chk("R7 data on port", port_d_o, d);
    chk("R7 strobe not yet", dav_n_o, 1);
    chk("R7 flag cleared", flag_o, 0);
    step(1);
    chk("R7 strobe one clock later", dav_n_o, 0);
    wdata_i = ~d;
    wr_i    = 1'b1;
    step(1);
    wr_i = 1'b0;
    chk("R9 busy write ignored", port_d_o, d);
    chk("R8 strobe held", dav_n_o, 0);
    rdy_i = 1'b0;
    step(2);
    chk("R8 strobe held in sync", dav_n_o, 0);
    step(1);
    chk("R8 strobe released", dav_n_o, 1);
    step(3);
    chk("R9 no done while rdy low", flag_o, 0);
    rdy_i = 1'b1;
    step(2);
    chk("R9 no done in sync", flag_o, 0);
    step(1);
    chk("R9 done", flag_o, 1);
    chk("R9 data unchanged", port_d_o, d);
    if (d[0]) begin
      rd_pulse();
      chk("R6 flag cleared", flag_o, 0);
    end
  endtask

  initial begin
    rst_ni = 1'b0; mode_i = 1'b0; port_d_i = '0; dav_n_i = 1'b1;
    rdy_i = 1'b1; wr_i = 1'b0; wdata_i = '0; rd_i = 1'b0;
    step(2);
    chk("R1 reset rdy", rdy_o, 1);
    chk("R1 reset dav", dav_n_o, 1);
    chk("R1 reset flag", flag_o, 0);
    chk("R1 reset oe", port_oe_o, 0);
    rst_ni = 1'b1;
    step(1);
    chk("R1 idle rdy", rdy_o, 1);
    chk("R1 idle flag", flag_o, 0);
    for (int v = 0; v < 256; v++) recv(v[7:0], v[0]);
    mode_i = 1'b1;
    step(1);
    chk("R1 tx oe", port_oe_o, 1);
    chk("R1 tx rdy", rdy_o, 0);
    chk("R1 tx dav", dav_n_o, 1);
    chk("R1 tx flag", flag_o, 0);
    for (int v = 0; v < 256; v++) send(v[7:0]);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule